// File: doc/BRIEF.md
# Ping-Pong Buffered DMA Channel

This block is a single DMA channel that moves transfer units between a peripheral and memory. It has two buffer descriptors, A and B. Each descriptor has a current-address register and an inclusive end-address register. When the channel finishes one buffer, it switches to the other buffer without software help. Software can refill the finished buffer while the other one streams, so a chained transfer has no gap.

Software sets up the channel through a write-only configuration port. It first writes the control word with the clear bit set, then writes the same word without clear, then programs the descriptors. The peripheral raises `per_req` for each unit it wants moved. The channel grants the request and issues one memory request at the aligned current address, and holds that address until memory acknowledges. A stop flag stored with an end address halts the channel after that buffer instead of swapping. Three status outputs report the channel state:

- overrun: the buffer in use is empty.
- interrupt: the enabled channel's idle buffer is empty and needs refilling.
- buffer select: which buffer is in use or will be used next.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, `mem_req`, `stat_irq` and `stat_sel` are 0 and `stat_overrun` is 1.
- R2: A control write (`cfg_sel`=4) with the clear bit (bit 7) set invalidates both buffers, selects buffer A and leaves the channel disabled whatever the enable bit (bit 6) holds. No memory request follows until a control write without clear sets enable.
- R3: Each granted peripheral request produces exactly one memory request. Its address is the current address of the selected buffer, and it stays stable until `mem_ack`. The current address then advances by one transfer unit.
- R4: Control bits [4:0] give the transfer unit in bytes, a power of two from 1 to 16. Address bits below the unit size are ignored, both in current addresses and in end addresses.
- R5: A buffer completes when the unit at its end address is acknowledged, so the end address is inclusive. Without a stop flag, `stat_sel` then toggles and the next unit comes from the other buffer.
- R6: Writing an end-address register (`cfg_sel` 1 for A, 3 for B) marks that buffer valid, and completing the buffer marks it invalid. No request is issued while the selected buffer is invalid.
- R7: `stat_irq` is 1 exactly when the channel is enabled and the buffer not selected is invalid.
- R8: `stat_overrun` is 1 exactly when the selected buffer is invalid.
- R9: End-address bit AW (bit 16 by default) is the stop flag. When a buffer carrying it completes, the channel disables itself, keeps `stat_sel` unchanged, and `stat_irq` falls.
- R10: `mem_write` follows control bit 5. A value of 1 means peripheral-to-memory, that is, a memory write.
- R11: While enable is 0, `per_req` is ignored and no memory request is made, even with a valid buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 cur A, 1 end A, 2 cur B, 3 end B, 4 control |
| cfg_wdata | input | AW+1 | Write data |
| per_req | input | 1 | Peripheral asks for one unit |
| per_grant | output | 1 | One-cycle pulse: request accepted |
| mem_req | output | 1 | Memory request pending |
| mem_ack | input | 1 | Memory acknowledges the pending request |
| mem_addr | output | AW | Unit-aligned memory address |
| mem_write | output | 1 | 1 = write memory (peripheral to memory) |
| stat_overrun | output | 1 | Selected buffer empty |
| stat_irq | output | 1 | Interrupt: idle buffer needs refill |
| stat_sel | output | 1 | Selected buffer, 0 = A, 1 = B |

## Verification
The assertions take three things for granted about the environment:

- Memory raises `mem_ack` only while `mem_req` is high.
- Software does not rewrite the current-address register of the buffer in use while a memory request is pending.
- Software does not change the unit size during a transfer.

The stimulus respects all three. Its memory responder acknowledges only pending requests, after a rotating delay of zero to two cycles. Descriptors are written either before enable or to the buffer that is not selected. The unit size is changed only together with a clear.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  typedef enum logic [2:0] {
    CFG_CUR_A = 3'd0,
    CFG_END_A = 3'd1,
    CFG_CUR_B = 3'd2,
    CFG_END_B = 3'd3,
    CFG_CTRL  = 3'd4
  } cfg_sel_e;

  localparam int UNIT_W  = 5;
  localparam int CTL_DIR = 5;
  localparam int CTL_EN  = 6;
  localparam int CTL_CLR = 7;

  // drop address bits below the unit size
  function automatic logic [31:0] unit_align(input logic [31:0] a,
                                             input logic [UNIT_W-1:0] sz);
    logic [31:0] m;
    m = {{(32-UNIT_W){1'b0}}, sz} - 32'd1;
    return a & ~m;
  endfunction

  function automatic logic [31:0] unit_next(input logic [31:0] a,
                                            input logic [UNIT_W-1:0] sz);
    return unit_align(a, sz) + {{(32-UNIT_W){1'b0}}, sz};
  endfunction

  // unit at address a is the final one of the buffer ending at e
  function automatic logic unit_last(input logic [31:0] a,
                                     input logic [31:0] e,
                                     input logic [UNIT_W-1:0] sz);
    return unit_align(a, sz) >= unit_align(e, sz);
  endfunction

endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_sel,
  input  logic [AW:0]             cfg_wdata,
  input  logic                    unit_done,
  input  logic                    done_sel,
  input  logic                    buf_last,
  input  logic                    stop_evt,
  output logic [1:0][AW-1:0]      cur_q,
  output logic [1:0][AW-1:0]      end_q,
  output logic [1:0]              stop_q,
  output logic [1:0]              valid_q,
  output logic                    ctl_en,
  output logic                    ctl_dir,
  output logic [UNIT_W-1:0]       ctl_size,
  output logic                    clr_pulse
);

  logic ctl_wr;
  assign ctl_wr    = cfg_we && (cfg_sel == CFG_CTRL);
  assign clr_pulse = ctl_wr && cfg_wdata[CTL_CLR];

  for (genvar b = 0; b < 2; b++) begin : g_buf
    localparam logic [2:0] SEL_CUR = 3'(2 * b);
    localparam logic [2:0] SEL_END = 3'(2 * b + 1);
    logic [AW-1:0] cur_next;
    logic          mine;
    assign cur_next = AW'(unit_next(32'(cur_q[b]), ctl_size));
    assign mine     = unit_done && (done_sel == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[b]   <= '0;
        end_q[b]   <= '0;
        stop_q[b]  <= 1'b0;
        valid_q[b] <= 1'b0;
      end else if (clr_pulse) begin
        valid_q[b] <= 1'b0;
      end else begin
        if (mine) begin
          cur_q[b] <= cur_next;
          if (buf_last) valid_q[b] <= 1'b0;
        end
        if (cfg_we && cfg_sel == SEL_CUR) cur_q[b] <= cfg_wdata[AW-1:0];
        if (cfg_we && cfg_sel == SEL_END) begin
          end_q[b]   <= cfg_wdata[AW-1:0];
          stop_q[b]  <= cfg_wdata[AW];
          valid_q[b] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_dir  <= 1'b0;
      ctl_size <= UNIT_W'(1);
    end else if (ctl_wr) begin
      ctl_size <= cfg_wdata[UNIT_W-1:0];
      ctl_dir  <= cfg_wdata[CTL_DIR];
      ctl_en   <= cfg_wdata[CTL_EN] && !cfg_wdata[CTL_CLR];
    end else if (stop_evt) begin
      ctl_en <= 1'b0;
    end
  end

  // R2: a clear leaves both buffers empty and the channel off
  assert_clear_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (valid_q == 2'b00) && !ctl_en);

  // R9: the stop event turns the channel off unless software rewrites control
  assert_stop_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !ctl_wr |=> !ctl_en);

endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
  import pp_dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ctl_en,
  input  logic [UNIT_W-1:0]   ctl_size,
  input  logic [1:0][AW-1:0]  cur_q,
  input  logic [1:0][AW-1:0]  end_q,
  input  logic [1:0]          stop_q,
  input  logic [1:0]          valid_q,
  input  logic                per_req,
  input  logic                mem_ack,
  output logic                per_grant,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  output logic                unit_done,
  output logic                buf_last,
  output logic                stop_evt,
  output logic                sel_q
);

  logic busy_q;

  assign per_grant = ctl_en && valid_q[sel_q] && per_req && !busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = AW'(unit_align(32'(cur_q[sel_q]), ctl_size));
  assign unit_done = busy_q && mem_ack;
  assign buf_last  = unit_done &&
                     unit_last(32'(cur_q[sel_q]), 32'(end_q[sel_q]), ctl_size);
  assign stop_evt  = buf_last && stop_q[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (clr) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      if (per_grant)      busy_q <= 1'b1;
      else if (unit_done) busy_q <= 1'b0;
      if (buf_last && !stop_q[sel_q]) sel_q <= ~sel_q;
    end
  end

  // R3: address held while the memory side has not answered
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !clr |=> mem_req && $stable(mem_addr));

  // R4: every issued address is aligned to the unit
  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((32'(mem_addr) & ({27'b0, ctl_size} - 32'd1)) == 32'd0));

  // R6: a request in flight always belongs to a valid buffer
  assert_req_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> valid_q[sel_q]);

  // R5: completing a buffer without stop hands over to the other one
  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_last && !stop_q[sel_q] && !clr |=> sel_q != $past(sel_q));

endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW:0]   cfg_wdata,
  input  logic          per_req,
  output logic          per_grant,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_write,
  output logic          stat_overrun,
  output logic          stat_irq,
  output logic          stat_sel
);

  logic [1:0][AW-1:0]  cur_q;
  logic [1:0][AW-1:0]  end_q;
  logic [1:0]          stop_q;
  logic [1:0]          valid_q;
  logic                ctl_en;
  logic                ctl_dir;
  logic [UNIT_W-1:0]   ctl_size;
  logic                clr_pulse;
  logic                unit_done;
  logic                buf_last;
  logic                stop_evt;
  logic                sel_q;

  pp_dma_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .unit_done(unit_done), .done_sel(sel_q), .buf_last(buf_last),
    .stop_evt(stop_evt),
    .cur_q(cur_q), .end_q(end_q), .stop_q(stop_q), .valid_q(valid_q),
    .ctl_en(ctl_en), .ctl_dir(ctl_dir), .ctl_size(ctl_size),
    .clr_pulse(clr_pulse)
  );

  pp_dma_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse),
    .ctl_en(ctl_en), .ctl_size(ctl_size),
    .cur_q(cur_q), .end_q(end_q), .stop_q(stop_q), .valid_q(valid_q),
    .per_req(per_req), .mem_ack(mem_ack),
    .per_grant(per_grant), .mem_req(mem_req), .mem_addr(mem_addr),
    .unit_done(unit_done), .buf_last(buf_last), .stop_evt(stop_evt),
    .sel_q(sel_q)
  );

  assign mem_write    = ctl_dir;
  assign stat_sel     = sel_q;
  assign stat_overrun = !valid_q[sel_q];
  assign stat_irq     = ctl_en && !valid_q[~sel_q];

  // R11: a new request never starts while the channel is off
  assert_no_req_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && !ctl_en |=> !mem_req);

  // R9: once the stop buffer has finished, the interrupt line is quiet
  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !(cfg_we && cfg_sel == CFG_CTRL) |=> !stat_irq);

endmodule

// File: tb/pp_dma_chan_tb.sv
`timescale 1ns/1ps
module pp_dma_chan_tb_top;
  localparam int AW = 16;
  localparam int STOP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW:0]   cfg_wdata = '0;
  logic          per_req = 1'b0;
  logic          per_grant;
  logic          mem_req;
  logic          mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_write;
  logic          stat_overrun, stat_irq, stat_sel;

  int total = 0;
  int bad = 0;
  logic [AW:0] exp_q[$];

  always #2 clk = ~clk;

  pp_dma_chan #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .per_req(per_req), .per_grant(per_grant),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_write(mem_write), .stat_overrun(stat_overrun),
    .stat_irq(stat_irq), .stat_sel(stat_sel)
  );

  task automatic chk(input string tag, input logic ok,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = (AW+1)'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // ctrl word: bit7 clear, bit6 enable, bit5 dir, [4:0] unit bytes
  function automatic int ctl(input bit c, input bit e, input bit d, input int sz);
    return (int'(c) << 7) | (int'(e) << 6) | (int'(d) << 5) | sz;
  endfunction

  // driver side of the scoreboard: expected unit addresses of one buffer
  task automatic push_buf(input int start, input int last, input int sz,
                          input bit w);
    int a, e;
    a = start & ~(sz - 1);
    e = last & ~(sz - 1);
    while (a <= e) begin
      exp_q.push_back({w, a[AW-1:0]});
      a += sz;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !mem_req && !mem_ack) break;
    end
    repeat (4) @(negedge clk);
    chk("R3 drain", exp_q.size() == 0, exp_q.size(), 0);
  endtask

  task automatic quiet(input string tag, input int n);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req) seen = 1'b1;
    end
    chk(tag, !seen, int'(seen), 0);
  endtask

  task automatic stat(input string tag, input bit ov, input bit iq, input bit sl);
    chk({tag, " overrun"}, stat_overrun == ov, int'(stat_overrun), int'(ov));
    chk({tag, " irq"},     stat_irq == iq,     int'(stat_irq),     int'(iq));
    chk({tag, " sel"},     stat_sel == sl,     int'(stat_sel),     int'(sl));
  endtask

  // monitor and memory responder with rotating latency
  initial begin
    int dly, wcnt;
    logic [AW:0] e;
    dly = 0; wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wcnt == 0) begin
          if (exp_q.size() == 0) chk("R3 unexpected request", 1'b0, int'(mem_addr), 0);
          else begin
            e = exp_q.pop_front();
            chk("R3/R4/R5 address", mem_addr == e[AW-1:0], int'(mem_addr), int'(e[AW-1:0]));
            chk("R10 direction", mem_write == e[AW], int'(mem_write), int'(e[AW]));
          end
          mem_ack = 1'b1;
          dly = (dly + 1) % 3;
          wcnt = dly;
        end else wcnt--;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", mem_req == 1'b0, int'(mem_req), 0);
    stat("R1", 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // word units, peripheral-to-memory, A alone first
    wr(3'd4, ctl(1, 1, 1, 4));
    wr(3'd0, 'h100);
    wr(3'd1, 'h10C);
    per_req = 1'b1;
    quiet("R2 enable ignored with clear", 12);
    wr(3'd4, ctl(0, 1, 1, 4));
    stat("R7/R8 A valid B empty", 1'b0, 1'b1, 1'b0);
    push_buf('h100, 'h10C, 4, 1'b1);
    drain();
    stat("R5/R8 swapped to empty B", 1'b1, 1'b1, 1'b1);
    quiet("R6 no request from invalid buffer", 10);
    // unaligned descriptors on B, low bits ignored (R4)
    push_buf('h200, 'h204, 4, 1'b1);
    wr(3'd2, 'h203);
    wr(3'd3, 'h207);
    drain();
    stat("R5 back to A both empty", 1'b1, 1'b1, 1'b0);

    // byte units, memory-to-peripheral, B ends with stop (R9)
    wr(3'd4, ctl(1, 0, 0, 1));
    wr(3'd4, ctl(0, 1, 0, 1));
    push_buf('h50, 'h52, 1, 1'b0);
    push_buf('h60, 'h61, 1, 1'b0);
    wr(3'd0, 'h50);
    wr(3'd1, 'h52);
    wr(3'd2, 'h60);
    wr(3'd3, 'h61 | STOP);
    drain();
    stat("R9 stopped on B", 1'b1, 1'b0, 1'b1);
    wr(3'd1, 'h55);
    quiet("R11 disabled ignores per_req", 20);
    chk("R7 irq off while disabled", stat_irq == 1'b0, int'(stat_irq), 0);

    // 16-byte units, both buffers primed before enable
    wr(3'd4, ctl(1, 1, 1, 16));
    chk("R2 buffers cleared", stat_overrun == 1'b1, int'(stat_overrun), 1);
    chk("R2 sel to A", stat_sel == 1'b0, int'(stat_sel), 0);
    wr(3'd0, 'h1007);
    wr(3'd1, 'h102F);
    wr(3'd2, 'h2000);
    wr(3'd3, 'h2000 | STOP);
    quiet("R2 still disabled after clear", 10);
    chk("R7 no irq before start", stat_irq == 1'b0, int'(stat_irq), 0);
    push_buf('h1000, 'h1020, 16, 1'b1);
    push_buf('h2000, 'h2000, 16, 1'b1);
    wr(3'd4, ctl(0, 1, 1, 16));
    drain();
    stat("R9 single-unit stop buffer", 1'b1, 1'b0, 1'b1);
    per_req = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule